// File: doc/BRIEF.md
# DMA Channel Status and Abort Register

This block is the per-channel status and abort register of a descriptor-driven DMA engine. The engine reports events to it as single-cycle pulses: a descriptor completes, either through a finished event or through a done event, and carries its own two interrupt-enable bits. The engine also reports when it follows a chain link, when it detects an error, and when it reaches a halt. The block keeps one sticky flag for each kind of event. The CPU reads these flags and clears them over a simple register bus. It also drives an interrupt line, which is the OR of all flags that the CPU has unmasked.

The CPU stops the channel by writing a one to the abort bit. The block then holds an abort request to the engine until the halted flag sets, and that flag is the acknowledgement. While the request is outstanding, the block suppresses CPU writes to the current-descriptor and next-descriptor pointer registers. If no transfer is running when the request is raised, the block produces the halted flag by itself on the following cycle.

Top module: `dma_chan_status`

## Requirements
- R1: After reset all five flags read 0, and `abortReq`, `irq`, `curPtrWe` and `nextPtrWe` are all 0.
- R2: Flag F (status bit 0) sets on the edge after a `descCompl` pulse with `complIsFinished`=1 and `ieFinished`=1. A completion with `ieFinished`=0, or with `complIsFinished`=0, leaves F unchanged.
- R3: Flag D (status bit 1) sets on the edge after a `descCompl` pulse with `complIsFinished`=0 and `ieDone`=1. A completion with `ieDone`=0, or with `complIsFinished`=1, leaves D unchanged.
- R4: Flag C (bit 2) sets on the edge after `chainEvt`, and flag E (bit 3) sets on the edge after `errEvt`. Both stay set until the CPU clears them.
- R5: Every flag is sticky and write-one-to-clear. A bus write to the status address clears exactly the flags in bits 4..0 whose data bit is 1. Writing a 0 bit leaves that flag alone. A write to any other address leaves every flag unchanged.
- R6: When a hardware set of a flag and a CPU clear of that same flag fall in the same cycle, the flag is 1 afterwards.
- R7: A status write with bit 5 = 1 raises `abortReq` on the next edge. A status read returns bit 5 and bits DATA_W-1..6 as 0. A read of any address other than the status address returns 0.
- R8: `abortReq` stays high while `xferActive` is 1 and `haltEvt` is absent. Flag H (bit 4) sets on the edge after `haltEvt`, or on the edge after a cycle in which `abortReq` is high and `xferActive` is 0. `abortReq` falls on the same edge at which H sets.
- R9: `curPtrWe` equals a bus write to the current-pointer address, and `nextPtrWe` equals a bus write to the next-pointer address, except in cycles where `abortReq` is high. In those cycles both outputs are 0.
- R10: `irq` is 1 exactly when some status flag in bits 4..0 is set and the matching bit of `irqMask` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWrEn | input | 1 | Register bus write strobe |
| busAddr | input | ADDR_W | Register bus word address |
| busWrData | input | DATA_W | Register bus write data |
| busRdData | output | DATA_W | Register bus read data (combinational on busAddr) |
| irqMask | input | 5 | Per-flag interrupt enable |
| descCompl | input | 1 | Descriptor completion pulse |
| complIsFinished | input | 1 | Completion cause: 1 finished event, 0 done event |
| ieFinished | input | 1 | Finished-interrupt enable of the completing descriptor |
| ieDone | input | 1 | Done-interrupt enable of the completing descriptor |
| chainEvt | input | 1 | Engine followed a chain link |
| errEvt | input | 1 | Engine detected an error |
| haltEvt | input | 1 | Engine reached the halted state |
| xferActive | input | 1 | A transfer is in progress |
| abortReq | output | 1 | Abort request to the engine |
| curPtrWe | output | 1 | Gated write enable of the current-descriptor pointer |
| nextPtrWe | output | 1 | Gated write enable of the next-descriptor pointer |
| irq | output | 1 | Masked OR of the status flags |

## Verification
Completions are driven with each combination of cause and enable bits. This shows whether F and D are qualified by their own enable bit or are set by any completion. Write-one-to-clear patterns are sent to the status address, and the same data is sent to a foreign address, to show clearing by bit apart from clearing of the whole register. A chain event coincides with a clear of C to fix the priority between set and clear. The abort is tried once with a transfer running and acknowledged through a halt event, and once while the engine is idle. This shows the two ways H can set, and it shows that pointer writes are blocked only during the pending window.

// File: rtl/dma_stat_pkg.sv
package dma_stat_pkg;
  localparam int NUM_FLAGS = 5;
  // Bit positions inside the status word
  localparam int FIN_BIT   = 0;
  localparam int DONE_BIT  = 1;
  localparam int CHAIN_BIT = 2;
  localparam int ERR_BIT   = 3;
  localparam int HALT_BIT  = 4;
  localparam int ABORT_BIT = 5;

  // Strobes handed from control to datapath each cycle
  typedef struct packed {
    logic [NUM_FLAGS-1:0] setVec;
    logic [NUM_FLAGS-1:0] clrVec;
    logic                 abortWr;
  } statStrobe_t;
endpackage

// File: rtl/dma_stat_ctrl.sv
module dma_stat_ctrl
  import dma_stat_pkg::*;
#(
  parameter int ADDR_W        = 4,
  parameter int DATA_W        = 32,
  parameter int STAT_ADDR     = 0,
  parameter int CUR_PTR_ADDR  = 1,
  parameter int NEXT_PTR_ADDR = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  input  logic              descCompl,
  input  logic              complIsFinished,
  input  logic              ieFinished,
  input  logic              ieDone,
  input  logic              chainEvt,
  input  logic              errEvt,
  input  logic              haltEvt,
  input  logic              xferActive,
  input  logic              abortPending,
  output statStrobe_t       strobe,
  output logic              curPtrWe,
  output logic              nextPtrWe
);
  localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_ADDR);
  localparam logic [ADDR_W-1:0] CUR_A  = ADDR_W'(CUR_PTR_ADDR);
  localparam logic [ADDR_W-1:0] NEXT_A = ADDR_W'(NEXT_PTR_ADDR);

  logic statWr;
  logic idleAbort;
  wire  unusedHiBits = ^busWrData[DATA_W-1:ABORT_BIT+1];

  assign statWr    = busWrEn && (busAddr == STAT_A);
  assign idleAbort = abortPending && !xferActive;

  always_comb begin
    strobe = '0;
    strobe.setVec[FIN_BIT]   = descCompl && complIsFinished && ieFinished;
    strobe.setVec[DONE_BIT]  = descCompl && !complIsFinished && ieDone;
    strobe.setVec[CHAIN_BIT] = chainEvt;
    strobe.setVec[ERR_BIT]   = errEvt;
    strobe.setVec[HALT_BIT]  = haltEvt || idleAbort;
    strobe.clrVec            = statWr ? busWrData[NUM_FLAGS-1:0] : '0;
    strobe.abortWr           = statWr && busWrData[ABORT_BIT];
  end

  // Pointer registers are locked while an abort awaits its acknowledgement
  assign curPtrWe  = busWrEn && (busAddr == CUR_A)  && !abortPending;
  assign nextPtrWe = busWrEn && (busAddr == NEXT_A) && !abortPending;

  // R8: an idle engine with a pending abort must produce a halt set
  assert_idle_halt_R8: assert property (@(posedge clk) disable iff (!rstN)
    (abortPending && !xferActive) |-> strobe.setVec[HALT_BIT]);

  // R2/R3: a single completion never sets both F and D
  assert_one_cause_R2: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.setVec[FIN_BIT] && strobe.setVec[DONE_BIT]));
endmodule

// File: rtl/dma_stat_dp.sv
module dma_stat_dp
  import dma_stat_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  statStrobe_t          strobe,
  input  logic [NUM_FLAGS-1:0] irqMask,
  output logic [NUM_FLAGS-1:0] flagQ,
  output logic                 abortPending,
  output logic                 irq
);
  for (genvar g = 0; g < NUM_FLAGS; g++) begin : gFlag
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        flagQ[g] <= 1'b0;
      else if (strobe.setVec[g] || strobe.clrVec[g])
        flagQ[g] <= strobe.setVec[g];
    end

    // R5: a flag not being cleared keeps its value of 1
    assert_sticky_R5: assert property (@(posedge clk) disable iff (!rstN)
      (flagQ[g] && !strobe.clrVec[g]) |=> flagQ[g]);
    // R6: a set always lands, even against a clear
    assert_set_wins_R6: assert property (@(posedge clk) disable iff (!rstN)
      strobe.setVec[g] |=> flagQ[g]);
    // R5: a clear without a set empties the flag
    assert_clear_R5: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.clrVec[g] && !strobe.setVec[g]) |=> !flagQ[g]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      abortPending <= 1'b0;
    else if (strobe.abortWr)
      abortPending <= 1'b1;
    else if (strobe.setVec[HALT_BIT])
      abortPending <= 1'b0;
  end

  assign irq = |(flagQ & irqMask);
endmodule

// File: rtl/dma_chan_status.sv
module dma_chan_status
  import dma_stat_pkg::*;
#(
  parameter int ADDR_W        = 4,
  parameter int DATA_W        = 32,
  parameter int STAT_ADDR     = 0,
  parameter int CUR_PTR_ADDR  = 1,
  parameter int NEXT_PTR_ADDR = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 busWrEn,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic [DATA_W-1:0]    busWrData,
  output logic [DATA_W-1:0]    busRdData,
  input  logic [NUM_FLAGS-1:0] irqMask,
  input  logic                 descCompl,
  input  logic                 complIsFinished,
  input  logic                 ieFinished,
  input  logic                 ieDone,
  input  logic                 chainEvt,
  input  logic                 errEvt,
  input  logic                 haltEvt,
  input  logic                 xferActive,
  output logic                 abortReq,
  output logic                 curPtrWe,
  output logic                 nextPtrWe,
  output logic                 irq
);
  localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_ADDR);

  statStrobe_t          strobe;
  logic [NUM_FLAGS-1:0] flagQ;
  logic                 abortPending;

  dma_stat_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .STAT_ADDR(STAT_ADDR),
    .CUR_PTR_ADDR(CUR_PTR_ADDR), .NEXT_PTR_ADDR(NEXT_PTR_ADDR)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWrData(busWrData), .descCompl(descCompl),
    .complIsFinished(complIsFinished), .ieFinished(ieFinished),
    .ieDone(ieDone), .chainEvt(chainEvt), .errEvt(errEvt),
    .haltEvt(haltEvt), .xferActive(xferActive),
    .abortPending(abortPending), .strobe(strobe),
    .curPtrWe(curPtrWe), .nextPtrWe(nextPtrWe)
  );

  dma_stat_dp uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .irqMask(irqMask),
    .flagQ(flagQ), .abortPending(abortPending), .irq(irq)
  );

  assign abortReq  = abortPending;
  assign busRdData = (busAddr == STAT_A) ? {{(DATA_W-NUM_FLAGS){1'b0}}, flagQ} : '0;

  // R7: an abort write raises the request
  assert_abort_raise_R7: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == STAT_A && busWrData[ABORT_BIT]) |=> abortReq);
  // R8: an idle engine acknowledges in one cycle and the request drops
  assert_abort_ack_R8: assert property (@(posedge clk) disable iff (!rstN)
    (abortReq && !xferActive) |=> (flagQ[HALT_BIT] && !abortReq));
  // R9: no pointer write escapes while an abort is pending
  assert_ptr_lock_R9: assert property (@(posedge clk) disable iff (!rstN)
    abortReq |-> (!curPtrWe && !nextPtrWe));
  // R2: qualified finished completion sets F
  assert_fin_set_R2: assert property (@(posedge clk) disable iff (!rstN)
    (descCompl && complIsFinished && ieFinished) |=> flagQ[FIN_BIT]);
endmodule

// File: tb/sim_dma_chan_status.sv
`timescale 1ns/1ps
module sim_dma_chan_status;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 32;
  localparam int WATCHDOG_CYCLES = 5000;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              busWrEn = 1'b0;
  logic [ADDR_W-1:0] busAddr = '0;
  logic [DATA_W-1:0] busWrData = '0;
  logic [DATA_W-1:0] busRdData;
  logic [4:0]        irqMask = 5'h1f;
  logic descCompl = 0, complIsFinished = 0, ieFinished = 0, ieDone = 0;
  logic chainEvt = 0, errEvt = 0, haltEvt = 0, xferActive = 0;
  logic abortReq, curPtrWe, nextPtrWe, irq;

  always #10 clk = ~clk;

  dma_chan_status u0 (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData), .irqMask(irqMask),
    .descCompl(descCompl), .complIsFinished(complIsFinished),
    .ieFinished(ieFinished), .ieDone(ieDone), .chainEvt(chainEvt),
    .errEvt(errEvt), .haltEvt(haltEvt), .xferActive(xferActive),
    .abortReq(abortReq), .curPtrWe(curPtrWe), .nextPtrWe(nextPtrWe), .irq(irq)
  );

  typedef struct {
    string             tag;
    logic [DATA_W-1:0] rd;
    logic              ab;
    logic              irqExp;
    logic              cw;
    logic              nw;
  } expItem_t;

  expItem_t expQ[$];
  int  checks = 0;
  int  fails = 0;
  bit  finished = 0;

  // Requirement model
  logic [4:0] mFlags = '0;
  logic       mPend = 1'b0;

  task automatic idleInputs();
    busWrEn = 0; busAddr = '0; busWrData = '0;
    descCompl = 0; complIsFinished = 0; ieFinished = 0; ieDone = 0;
    chainEvt = 0; errEvt = 0; haltEvt = 0;
  endtask

  // Driver: push what the outputs must be in this cycle, then advance the model
  task automatic cyc(input string tag);
    expItem_t it;
    logic [4:0] setV, clrV;
    logic statWr;
    statWr    = busWrEn && busAddr == 0;
    it.tag    = tag;
    it.rd     = (busAddr == 0) ? {27'd0, mFlags} : '0;
    it.ab     = mPend;
    it.irqExp = |(mFlags & irqMask);
    it.cw     = busWrEn && busAddr == 1 && !mPend;
    it.nw     = busWrEn && busAddr == 2 && !mPend;
    expQ.push_back(it);
    @(posedge clk);
    setV[0] = descCompl && complIsFinished && ieFinished;
    setV[1] = descCompl && !complIsFinished && ieDone;
    setV[2] = chainEvt;
    setV[3] = errEvt;
    setV[4] = haltEvt || (mPend && !xferActive);
    clrV    = statWr ? busWrData[4:0] : 5'd0;
    mFlags  = (mFlags & ~clrV) | setV;
    mPend   = (mPend && !setV[4]) || (statWr && busWrData[5]);
    #1;
    idleInputs();
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    busWrEn = 1; busAddr = a; busWrData = d;
  endtask

  // Monitor: compare at the falling edge
  always @(negedge clk) begin
    while (expQ.size() > 0) begin
      expItem_t e;
      e = expQ.pop_front();
      checks++;
      if (busRdData !== e.rd || abortReq !== e.ab || irq !== e.irqExp ||
          curPtrWe !== e.cw || nextPtrWe !== e.nw) begin
        fails++;
        $display("FAIL %s: rd=%h ab=%b irq=%b cw=%b nw=%b expected rd=%h ab=%b irq=%b cw=%b nw=%b",
                 e.tag, busRdData, abortReq, irq, curPtrWe, nextPtrWe,
                 e.rd, e.ab, e.irqExp, e.cw, e.nw);
      end
    end
  end

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    idleInputs();
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    cyc("R1 reset state");
    // R2: finished completion without its enable
    descCompl = 1; complIsFinished = 1; ieFinished = 0; ieDone = 1; cyc("R2 unqualified");
    cyc("R2 F stays clear");
    descCompl = 1; complIsFinished = 1; ieFinished = 1; cyc("R2 qualified");
    cyc("R2 F set");
    // R3: done completion
    descCompl = 1; complIsFinished = 0; ieDone = 0; ieFinished = 1; cyc("R3 unqualified");
    cyc("R3 D stays clear");
    descCompl = 1; complIsFinished = 0; ieDone = 1; cyc("R3 qualified");
    cyc("R3 D set");
    // R4
    chainEvt = 1; cyc("R4 chain");
    errEvt = 1; cyc("R4 error");
    cyc("R4 C and E set");
    // R10 masks
    irqMask = 5'h00; cyc("R10 all masked");
    irqMask = 5'h08; cyc("R10 error unmasked");
    irqMask = 5'h10; cyc("R10 halt unmasked, halt clear");
    irqMask = 5'h1f;
    // R5 write-one-to-clear
    wr(4'd3, 32'hffff_ffff); cyc("R5 foreign address");
    cyc("R5 no flag lost");
    wr(0, 32'h0000_0000); cyc("R5 zero write");
    cyc("R5 zero write keeps flags");
    wr(0, 32'h0000_0003); cyc("R5 clear F D");
    cyc("R5 F D cleared");
    // R6 set beats clear
    chainEvt = 1; wr(0, 32'h0000_0004); cyc("R6 set and clear");
    cyc("R6 C still set");
    wr(0, 32'h0000_000c); cyc("R5 clear C E");
    // R9 pointer writes free
    wr(1, 32'h1234); cyc("R9 cur pointer write");
    wr(2, 32'h5678); cyc("R9 next pointer write");
    // Abort with transfer running
    xferActive = 1;
    wr(0, 32'h0000_0020); cyc("R7 abort write");
    xferActive = 1; cyc("R7 abort reads zero");
    xferActive = 1; wr(1, 32'hdead); cyc("R9 cur locked");
    xferActive = 1; wr(2, 32'hbeef); cyc("R9 next locked");
    xferActive = 1; cyc("R8 held while active");
    xferActive = 1; haltEvt = 1; cyc("R8 halt event");
    xferActive = 0; cyc("R8 H set, request dropped");
    wr(1, 32'h4321); cyc("R9 unlocked after H");
    wr(0, 32'h0000_0010); cyc("R5 clear H");
    // Abort while idle
    wr(0, 32'h0000_0020); cyc("R8 idle abort write");
    cyc("R8 idle pending one cycle");
    wr(2, 32'h1); cyc("R8 H from idle abort");
    // Upper bits and full write
    wr(0, 32'hffff_ffff); cyc("R7 full write clears and aborts");
    busAddr = 0; cyc("R7 upper bits zero");
    busAddr = 4'd5; cyc("R7 foreign read zero");
    @(negedge clk); #1;
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule